// File: doc/BRIEF.md
# Parallel Memory Bus Cycle Sequencer

This block runs read and write cycles on an external asynchronous parallel bus whose data path is either 8 or 16 bits wide. Every bus cycle goes through four phases in fixed order: a setup phase with address and direction already valid, a strobe phase with the active-low read or write strobe asserted, a hold phase with the strobe released, and a pace phase that keeps the bus idle before the next cycle. Reads and writes each have their own set of four phase lengths and their own width selection. All lengths are counted in clock cycles.

There are two ways to start work. A direct transfer runs one cycle at its own address, with its own write word and its own done flag. A programmed burst runs a counted number of back-to-back cycles at a second address. Its write words are taken from a streaming input one per cycle, and the block reports an active flag and a completion flag for it. The count is given in bus transfers, not bytes.

Top module: `pbus_seq`

## Requirements
- R1: After reset both strobes are high, the data drive enable is low, and active, prog_done, dir_done and rvalid are all low.
- R2: A cycle holds setup for S clocks, then strobe for T clocks, then hold for H clocks, then pace for P clocks. A read cycle uses the read set of lengths and a write cycle uses the write set, and neither set affects the other kind of cycle.
- R3: A phase length programmed as 0 behaves as 1 clock, so every phase is present in every cycle.
- R4: Read data is taken from bus_din on the last clock of the strobe phase. It appears on rdata with a one-clock rvalid pulse during the first hold clock. In 8-bit mode rdata holds bus_din[7:0] with the upper byte zero.
- R5: During a write cycle bus_oe is high from the first setup clock through the last pace clock. In 16-bit mode bus_dout carries the whole word. In 8-bit mode bus_dout[7:0] carries the low byte of the word, or the high byte when wr_swap is set, and bus_dout[15:8] is zero. The swap input has no effect in 16-bit mode.
- R6: While the sequencer is idle and enable is high, a dir_start pulse runs one cycle at dir_addr in the direction given by dir_write. Acceptance clears dir_done, and dir_done rises on the clock after the last pace clock and stays high until the next accepted dir_start. A dir_start with enable low is ignored.
- R7: A prog_start pulse with enable high and burst_len of N (N > 0) runs N back-to-back cycles at prog_addr in the direction given by prog_write. Active is high from the first setup clock through the last pace clock. prog_done rises on the clock after the last pace clock and is cleared by prog_clear or by the next accepted burst.
- R8: A prog_start with burst_len 0 runs no bus cycle, leaves active low, and sets prog_done on the next clock.
- R9: When enable drops during a burst, the cycle in progress finishes and no further cycle starts. Active then falls, and prog_done stays low.
- R10: A dir_start that arrives while a transfer is running is ignored, and dir_done keeps its value. When prog_start and dir_start arrive in the same clock, the burst wins.
- R11: bus_addr does not change from the first setup clock to the last pace clock of a transfer, and it changes nowhere inside a burst.
- R12: Each programmed write cycle latches prog_wdata at its setup entry. wbeat pulses on that cycle's first setup clock to show the word was consumed, and the next word is latched at the next cycle's setup entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Permits new transfers; when low, a burst stops after its current cycle |
| rd_setup | input | TW | Read setup length in clocks |
| rd_strobe | input | TW | Read strobe length in clocks |
| rd_hold | input | TW | Read hold length in clocks |
| rd_pace | input | TW | Read pace length in clocks |
| rd_wide | input | 1 | 1 = 16-bit reads, 0 = 8-bit reads |
| wr_setup | input | TW | Write setup length in clocks |
| wr_strobe | input | TW | Write strobe length in clocks |
| wr_hold | input | TW | Write hold length in clocks |
| wr_pace | input | TW | Write pace length in clocks |
| wr_wide | input | 1 | 1 = 16-bit writes, 0 = 8-bit writes |
| wr_swap | input | 1 | In 8-bit writes, send the high byte of the word |
| dir_start | input | 1 | Pulse that starts a direct single cycle |
| dir_write | input | 1 | Direction of the direct cycle (1 = write) |
| dir_addr | input | AW | Address of the direct cycle |
| dir_wdata | input | DW | Write word of the direct cycle |
| dir_done | output | 1 | Direct cycle finished |
| prog_start | input | 1 | Pulse that starts a programmed burst |
| prog_write | input | 1 | Direction of the burst (1 = write) |
| prog_clear | input | 1 | Pulse that clears prog_done |
| burst_len | input | CW | Burst length in bus transfers |
| prog_addr | input | AW | Address of the burst |
| prog_wdata | input | DW | Next write word of the burst |
| wbeat | output | 1 | A burst write word was consumed |
| active | output | 1 | Burst in progress |
| prog_done | output | 1 | Burst finished normally |
| rdata | output | DW | Last read word |
| rvalid | output | 1 | One-clock pulse marking a new rdata |
| bus_addr | output | AW | Bus address |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_oe | output | 1 | Drive enable for bus_dout |
| bus_dout | output | DW | Bus write lanes |
| bus_din | input | DW | Bus read lanes |

## Verification
Take the start pulse as sampled at edge 0, and let S', T', H', P' be each phase length with 0 raised to 1. Then the strobe is seen low from clock S'+1 through S'+T'. rvalid and the new rdata are due at clock S'+T'+1, and dir_done or prog_done is due at clock N·(S'+T'+H'+P')+1. The bench drives a different bus_din value on every clock, so the captured word also shows on which clock it was sampled. Every observation is taken on the falling clock edge and indexed by the number of rising edges since the start. Each index is then compared with the closed-form value worked out from the programmed lengths. This is done over every read and write combination of lengths 0 to 2, and for bursts, zero-length bursts, enable drops and colliding starts.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_PACE   = 3'd4
  } pbus_phase_e;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_BURST  = 1'b1
  } pbus_mode_e;

endpackage

// File: rtl/pbus_phase_ctr.sv
module pbus_phase_ctr #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  input  logic          run,
  output logic          last,
  output logic          first
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          first_q, first_d;

  // a zero length is stretched to one clock
  always_comb begin
    cnt_d   = cnt_q;
    first_d = load;
    if (load) begin
      cnt_d = (len == '0) ? '0 : len - 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  assign last  = (cnt_q == '0);
  assign first = first_q;

endmodule

// File: rtl/pbus_xfer_ctr.sv
module pbus_xfer_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          dec,
  output logic          more
);

  logic [CW-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load) begin
      rem_d = len;
    end else if (dec) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else begin
      rem_q <= rem_d;
    end
  end

  assign more = (rem_q > CW'(1));

  // R7
  xfer_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (rem_q != '0));

endmodule

// File: rtl/pbus_lane.sv
module pbus_lane #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] wword,
  input  logic          w_wide,
  input  logic          w_swap,
  output logic [DW-1:0] wlanes,
  input  logic [DW-1:0] rlanes,
  input  logic          r_wide,
  output logic [DW-1:0] rword
);

  localparam int HW = DW / 2;

  logic [HW-1:0] narrow_byte;

  always_comb begin
    narrow_byte = w_swap ? wword[DW-1:HW] : wword[HW-1:0];
    wlanes      = w_wide ? wword : {{(DW-HW){1'b0}}, narrow_byte};
    rword       = r_wide ? rlanes : {{(DW-HW){1'b0}}, rlanes[HW-1:0]};
  end

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int TW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [TW-1:0] rd_setup,
  input  logic [TW-1:0] rd_strobe,
  input  logic [TW-1:0] rd_hold,
  input  logic [TW-1:0] rd_pace,
  input  logic          rd_wide,
  input  logic [TW-1:0] wr_setup,
  input  logic [TW-1:0] wr_strobe,
  input  logic [TW-1:0] wr_hold,
  input  logic [TW-1:0] wr_pace,
  input  logic          wr_wide,
  input  logic          wr_swap,
  input  logic          dir_start,
  input  logic          dir_write,
  input  logic [AW-1:0] dir_addr,
  input  logic [DW-1:0] dir_wdata,
  output logic          dir_done,
  input  logic          prog_start,
  input  logic          prog_write,
  input  logic          prog_clear,
  input  logic [CW-1:0] burst_len,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_wdata,
  output logic          wbeat,
  output logic          active,
  output logic          prog_done,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din
);

  pbus_phase_e   state_q, state_d;
  pbus_mode_e    mode_q, mode_d;
  logic          wr_q, wr_d;
  logic          wide_q, wide_d;
  logic          swap_q, swap_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic [DW-1:0] rdat_q, rdat_d;
  logic          act_q, act_d;
  logic          pdone_q, pdone_d;
  logic          ddone_q, ddone_d;

  logic          idle, start_burst, zero_burst, start_dir;
  logic          cycle_end, cont, new_cyc, nxt_wr;
  logic          ph_load, ph_last, ph_first;
  logic [TW-1:0] ph_len;
  logic          more;
  logic [DW-1:0] rword;

  // ---------------- start decode ----------------
  always_comb begin
    idle        = (state_q == PH_IDLE);
    start_burst = idle && enable && prog_start && (burst_len != '0);
    zero_burst  = idle && enable && prog_start && (burst_len == '0);
    start_dir   = idle && enable && dir_start && !prog_start;
    cycle_end   = (state_q == PH_PACE) && ph_last;
    cont        = cycle_end && (mode_q == MODE_BURST) && more && enable;
    new_cyc     = start_burst || start_dir || cont;
    nxt_wr      = start_burst ? prog_write : (start_dir ? dir_write : wr_q);
  end

  // ---------------- phase sequencing ----------------
  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_IDLE:   if (start_burst || start_dir) state_d = PH_SETUP;
      PH_SETUP:  if (ph_last) state_d = PH_STROBE;
      PH_STROBE: if (ph_last) state_d = PH_HOLD;
      PH_HOLD:   if (ph_last) state_d = PH_PACE;
      PH_PACE:   if (ph_last) state_d = cont ? PH_SETUP : PH_IDLE;
      default:   state_d = PH_IDLE;
    endcase
  end

  always_comb begin
    ph_load = new_cyc ||
              (ph_last && ((state_q == PH_SETUP) || (state_q == PH_STROBE) ||
                           (state_q == PH_HOLD)));
    case (state_d)
      PH_SETUP:  ph_len = nxt_wr ? wr_setup  : rd_setup;
      PH_STROBE: ph_len = wr_q   ? wr_strobe : rd_strobe;
      PH_HOLD:   ph_len = wr_q   ? wr_hold   : rd_hold;
      PH_PACE:   ph_len = wr_q   ? wr_pace   : rd_pace;
      default:   ph_len = '0;
    endcase
  end

  pbus_phase_ctr #(.TW(TW)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ph_load),
    .len   (ph_len),
    .run   (!idle),
    .last  (ph_last),
    .first (ph_first)
  );

  pbus_xfer_ctr #(.CW(CW)) u_xfer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_burst),
    .len   (burst_len),
    .dec   (cycle_end && (mode_q == MODE_BURST)),
    .more  (more)
  );

  pbus_lane #(.DW(DW)) u_lane (
    .wword  (wdat_q),
    .w_wide (wide_q),
    .w_swap (swap_q),
    .wlanes (bus_dout),
    .rlanes (bus_din),
    .r_wide (wide_q),
    .rword  (rword)
  );

  // ---------------- datapath and status next-state ----------------
  always_comb begin
    mode_d  = mode_q;
    wr_d    = wr_q;
    wide_d  = wide_q;
    swap_d  = swap_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    rdat_d  = rdat_q;
    act_d   = act_q;
    pdone_d = pdone_q;
    ddone_d = ddone_q;

    if (start_burst) begin
      mode_d = MODE_BURST;
      addr_d = prog_addr;
    end else if (start_dir) begin
      mode_d = MODE_DIRECT;
      addr_d = dir_addr;
    end

    if (new_cyc) begin
      wr_d   = nxt_wr;
      wide_d = nxt_wr ? wr_wide : rd_wide;
      swap_d = wr_swap;
      wdat_d = start_dir ? dir_wdata : prog_wdata;
    end

    if ((state_q == PH_STROBE) && ph_last && !wr_q) begin
      rdat_d = rword;
    end

    if (start_burst) begin
      act_d = 1'b1;
    end else if (cycle_end && !cont) begin
      act_d = 1'b0;
    end

    if (zero_burst || (cycle_end && (mode_q == MODE_BURST) && !more)) begin
      pdone_d = 1'b1;
    end else if (prog_clear || start_burst) begin
      pdone_d = 1'b0;
    end

    if (start_dir) begin
      ddone_d = 1'b0;
    end else if (cycle_end && (mode_q == MODE_DIRECT)) begin
      ddone_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      mode_q  <= MODE_DIRECT;
      wr_q    <= 1'b0;
      wide_q  <= 1'b1;
      swap_q  <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      act_q   <= 1'b0;
      pdone_q <= 1'b0;
      ddone_q <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      wr_q    <= wr_d;
      wide_q  <= wide_d;
      swap_q  <= swap_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      rdat_q  <= rdat_d;
      act_q   <= act_d;
      pdone_q <= pdone_d;
      ddone_q <= ddone_d;
    end
  end

  // ---------------- outputs ----------------
  assign bus_addr  = addr_q;
  assign bus_rd_n  = !((state_q == PH_STROBE) && !wr_q);
  assign bus_wr_n  = !((state_q == PH_STROBE) && wr_q);
  assign bus_oe    = wr_q && !idle;
  assign rdata     = rdat_q;
  assign rvalid    = (state_q == PH_HOLD) && ph_first && !wr_q;
  assign wbeat     = (state_q == PH_SETUP) && ph_first && wr_q && (mode_q == MODE_BURST);
  assign active    = act_q;
  assign prog_done = pdone_q;
  assign dir_done  = ddone_q;

  // ---------------- assertions ----------------
  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != PH_IDLE) && ($past(state_q) != PH_IDLE)) |-> $stable(bus_addr));

  // R2
  strobe_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PH_STROBE) && ($past(state_q) != PH_STROBE)) |-> ($past(state_q) == PH_SETUP));

  // R9
  active_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(state_q) == PH_PACE));

  // R4
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !$past(bus_rd_n));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdone_q) |-> !act_q);

  // R5
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_oe);

endmodule

// File: tb/pbus_seq_tb.sv
`timescale 1ns/100ps
module pbus_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [3:0]  rd_setup, rd_strobe, rd_hold, rd_pace;
  logic [3:0]  wr_setup, wr_strobe, wr_hold, wr_pace;
  logic        rd_wide, wr_wide, wr_swap;
  logic        dir_start, dir_write, dir_done;
  logic [7:0]  dir_addr;
  logic [15:0] dir_wdata;
  logic        prog_start, prog_write, prog_clear;
  logic [7:0]  burst_len, prog_addr;
  logic [15:0] prog_wdata;
  logic        wbeat, active, prog_done, rvalid;
  logic [15:0] rdata;
  logic [7:0]  bus_addr;
  logic        bus_rd_n, bus_wr_n, bus_oe;
  logic [15:0] bus_dout, bus_din;

  int n_chk = 0;
  int n_bad = 0;

  int rd_first, rd_cnt, rd_pulses, wr_first, wr_cnt, wr_pulses, oe_cnt;
  int rv_cnt, rv_first, wb_cnt, act_first, act_last, pd_first, dd_first;
  int addr_bad, dout_bad;
  logic [15:0] rv_data, dout_first;

  always #2.5 clk = ~clk;

  pbus_seq #(.AW(8), .DW(16), .TW(4), .CW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .rd_setup(rd_setup), .rd_strobe(rd_strobe), .rd_hold(rd_hold), .rd_pace(rd_pace),
    .rd_wide(rd_wide),
    .wr_setup(wr_setup), .wr_strobe(wr_strobe), .wr_hold(wr_hold), .wr_pace(wr_pace),
    .wr_wide(wr_wide), .wr_swap(wr_swap),
    .dir_start(dir_start), .dir_write(dir_write), .dir_addr(dir_addr),
    .dir_wdata(dir_wdata), .dir_done(dir_done),
    .prog_start(prog_start), .prog_write(prog_write), .prog_clear(prog_clear),
    .burst_len(burst_len), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
    .wbeat(wbeat), .active(active), .prog_done(prog_done),
    .rdata(rdata), .rvalid(rvalid),
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  function automatic logic [15:0] din_val(input int i);
    return {8'(8'h40 + i), 8'(8'h80 + i)};
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic observe(input int n, input int drop_at, input int dpulse_at,
                         input logic [7:0] exp_addr);
    logic prd, pwr;
    prd = 1'b1; pwr = 1'b1;
    rd_first = 0; rd_cnt = 0; rd_pulses = 0; wr_first = 0; wr_cnt = 0; wr_pulses = 0;
    oe_cnt = 0; rv_cnt = 0; rv_first = 0; wb_cnt = 0; act_first = 0; act_last = 0;
    pd_first = 0; dd_first = 0; addr_bad = 0; dout_bad = 0;
    rv_data = '0; dout_first = '0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      dir_start = 1'b0; prog_start = 1'b0; prog_clear = 1'b0;
      if (i == drop_at) enable = 1'b0;
      if (i == dpulse_at) begin dir_start = 1'b1; dir_addr = 8'hEE; end
      if (!bus_rd_n) begin
        if (rd_first == 0) rd_first = i;
        rd_cnt++;
        if (prd) rd_pulses++;
        if (bus_addr != exp_addr) addr_bad++;
      end
      if (!bus_wr_n) begin
        if (wr_first == 0) wr_first = i;
        wr_cnt++;
        if (bus_addr != exp_addr) addr_bad++;
        if (pwr) begin
          wr_pulses++;
          if (wr_pulses == 1) dout_first = bus_dout;
          if (bus_dout != 16'(16'h2000 + wr_pulses - 1)) dout_bad++;
        end
      end
      prd = bus_rd_n; pwr = bus_wr_n;
      if (bus_oe) oe_cnt++;
      if (rvalid) begin
        rv_cnt++;
        if (rv_first == 0) begin rv_first = i; rv_data = rdata; end
      end
      if (wbeat) begin wb_cnt++; prog_wdata = 16'(16'h2000 + wb_cnt); end
      if (active) begin if (act_first == 0) act_first = i; act_last = i; end
      if (prog_done && pd_first == 0) pd_first = i;
      if (dir_done && dd_first == 0) dd_first = i;
      bus_din = din_val(i);
    end
  endtask

  task automatic pulse_dir(input logic wr, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    dir_write = wr; dir_addr = a; dir_wdata = d; dir_start = 1'b1;
    bus_din = din_val(0);
  endtask

  task automatic pulse_prog(input logic wr, input logic [7:0] len);
    @(negedge clk);
    prog_write = wr; burst_len = len; prog_start = 1'b1;
    prog_wdata = 16'h2000; bus_din = din_val(0);
  endtask

  task automatic clear_done();
    @(negedge clk);
    prog_clear = 1'b1;
    @(negedge clk);
    prog_clear = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1;
    rd_setup = 4'd1; rd_strobe = 4'd3; rd_hold = 4'd1; rd_pace = 4'd1; rd_wide = 1'b1;
    wr_setup = 4'd1; wr_strobe = 4'd3; wr_hold = 4'd1; wr_pace = 4'd1;
    wr_wide = 1'b1; wr_swap = 1'b0;
    dir_start = 1'b0; dir_write = 1'b0; dir_addr = '0; dir_wdata = '0;
    prog_start = 1'b0; prog_write = 1'b0; prog_clear = 1'b0;
    burst_len = '0; prog_addr = 8'h5C; prog_wdata = 16'h2000; bus_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_n", int'(bus_rd_n), 1);
    chk("R1 wr_n", int'(bus_wr_n), 1);
    chk("R1 oe", int'(bus_oe), 0);
    chk("R1 status", int'({active, prog_done, dir_done, rvalid}), 0);

    // R2 R3 R4 read timing sweep; write set kept at other values
    wr_setup = 4'd5; wr_strobe = 4'd5; wr_hold = 4'd5; wr_pace = 4'd5;
    for (int s = 0; s < 3; s++)
      for (int t = 0; t < 3; t++)
        for (int h = 0; h < 3; h++)
          for (int p = 0; p < 3; p++) begin
            int c;
            logic [7:0] a;
            rd_setup = 4'(s); rd_strobe = 4'(t); rd_hold = 4'(h); rd_pace = 4'(p);
            c = eff(s) + eff(t) + eff(h) + eff(p);
            a = 8'(s * 27 + t * 9 + h * 3 + p);
            pulse_dir(1'b0, a, 16'h0);
            observe(c + 3, 0, 0, a);
            chk("R2 R3 read setup", rd_first, eff(s) + 1);
            chk("R2 R3 read strobe", rd_cnt, eff(t));
            chk("R4 rvalid clock", rv_first, eff(s) + eff(t) + 1);
            chk("R4 rdata", int'(rv_data), int'(din_val(eff(s) + eff(t))));
            chk("R6 dir_done read", dd_first, c + 1);
            chk("R11 read addr", addr_bad, 0);
            chk("R2 no write on read", wr_cnt + oe_cnt, 0);
          end

    // R2 R3 R5 write timing sweep; read set kept at other values
    rd_setup = 4'd6; rd_strobe = 4'd6; rd_hold = 4'd6; rd_pace = 4'd6;
    for (int s = 0; s < 3; s++)
      for (int t = 0; t < 3; t++)
        for (int h = 0; h < 3; h++)
          for (int p = 0; p < 3; p++) begin
            int c;
            logic [7:0] a;
            logic [15:0] d;
            wr_setup = 4'(s); wr_strobe = 4'(t); wr_hold = 4'(h); wr_pace = 4'(p);
            c = eff(s) + eff(t) + eff(h) + eff(p);
            a = 8'(8'h80 + s * 27 + t * 9 + h * 3 + p);
            d = 16'(16'h3100 + s * 27 + t * 9 + h * 3 + p);
            pulse_dir(1'b1, a, d);
            observe(c + 3, 0, 0, a);
            chk("R2 R3 write setup", wr_first, eff(s) + 1);
            chk("R2 R3 write strobe", wr_cnt, eff(t));
            chk("R5 oe span", oe_cnt, c);
            chk("R5 dout 16", int'(dout_first), int'(d));
            chk("R6 dir_done write", dd_first, c + 1);
            chk("R11 write addr", addr_bad, 0);
            chk("R2 no read on write", rd_cnt + rv_cnt, 0);
          end

    // R4 R5 8-bit lanes and swap
    rd_setup = 4'd1; rd_strobe = 4'd2; rd_hold = 4'd1; rd_pace = 4'd1; rd_wide = 1'b0;
    wr_setup = 4'd1; wr_strobe = 4'd1; wr_hold = 4'd1; wr_pace = 4'd1;
    pulse_dir(1'b0, 8'h11, 16'h0);
    observe(8, 0, 0, 8'h11);
    chk("R4 8-bit rdata", int'(rv_data), int'({8'h00, din_val(3)[7:0]}));
    wr_wide = 1'b0; wr_swap = 1'b0;
    pulse_dir(1'b1, 8'h12, 16'hA55A);
    observe(7, 0, 0, 8'h12);
    chk("R5 8-bit low byte", int'(dout_first), 16'h005A);
    wr_swap = 1'b1;
    pulse_dir(1'b1, 8'h13, 16'hA55A);
    observe(7, 0, 0, 8'h13);
    chk("R5 8-bit swapped", int'(dout_first), 16'h00A5);
    wr_wide = 1'b1;
    pulse_dir(1'b1, 8'h14, 16'hA55A);
    observe(7, 0, 0, 8'h14);
    chk("R5 swap ignored wide", int'(dout_first), 16'hA55A);
    wr_swap = 1'b0; rd_wide = 1'b1;

    // R6 direct start with enable low is ignored
    enable = 1'b0;
    pulse_dir(1'b1, 8'h15, 16'h1);
    observe(12, 0, 0, 8'h15);
    chk("R6 disabled no strobe", rd_cnt + wr_cnt + oe_cnt, 0);
    chk("R6 dir_done kept", int'(dir_done), 1);
    enable = 1'b1;

    // R7 R12 burst write, lengths (0,1,0,2) -> 5 clocks per cycle
    wr_setup = 4'd0; wr_strobe = 4'd1; wr_hold = 4'd0; wr_pace = 4'd2;
    pulse_prog(1'b1, 8'd3);
    observe(20, 0, 0, 8'h5C);
    chk("R7 burst write pulses", wr_pulses, 3);
    chk("R7 active first", act_first, 1);
    chk("R7 active last", act_last, 15);
    chk("R7 done clock", pd_first, 16);
    chk("R11 burst addr", addr_bad, 0);
    chk("R12 wbeat count", wb_cnt, 3);
    chk("R12 word order", dout_bad, 0);
    clear_done();
    chk("R7 clear", int'(prog_done), 0);

    // R7 burst read, lengths (1,2,1,1) -> 5 clocks per cycle
    rd_setup = 4'd1; rd_strobe = 4'd2; rd_hold = 4'd1; rd_pace = 4'd1;
    pulse_prog(1'b0, 8'd2);
    observe(16, 0, 0, 8'h5C);
    chk("R7 burst read pulses", rd_pulses, 2);
    chk("R7 burst rvalid", rv_cnt, 2);
    chk("R7 read active last", act_last, 10);
    chk("R7 read done clock", pd_first, 11);
    chk("R12 no wbeat on read", wb_cnt, 0);
    clear_done();

    // R8 zero-length burst
    pulse_prog(1'b0, 8'd0);
    observe(8, 0, 0, 8'h5C);
    chk("R8 done next clock", pd_first, 1);
    chk("R8 active low", act_first, 0);
    chk("R8 no cycle", rd_cnt + wr_cnt + oe_cnt, 0);
    clear_done();

    // R9 enable dropped in second cycle of a 5-cycle burst, 4 clocks per cycle
    wr_setup = 4'd1; wr_strobe = 4'd1; wr_hold = 4'd1; wr_pace = 4'd1;
    pulse_prog(1'b1, 8'd5);
    observe(24, 5, 0, 8'h5C);
    chk("R9 cycles run", wr_pulses, 2);
    chk("R9 active last", act_last, 8);
    chk("R9 no done", pd_first, 0);
    enable = 1'b1;

    // R10 direct start during burst ignored
    rd_setup = 4'd1; rd_strobe = 4'd1; rd_hold = 4'd1; rd_pace = 4'd1;
    pulse_prog(1'b0, 8'd3);
    observe(20, 0, 3, 8'h5C);
    chk("R10 burst pulses", rd_pulses, 3);
    chk("R10 addr untouched", addr_bad, 0);
    chk("R10 active last", act_last, 12);
    chk("R10 dir_done kept", int'(dir_done), 1);
    clear_done();

    // R10 simultaneous starts: burst wins
    @(negedge clk);
    dir_write = 1'b1; dir_addr = 8'h77; dir_wdata = 16'h1; dir_start = 1'b1;
    prog_write = 1'b0; burst_len = 8'd1; prog_start = 1'b1; bus_din = din_val(0);
    observe(10, 0, 0, 8'h5C);
    chk("R10 burst read ran", rd_pulses, 1);
    chk("R10 direct dropped", wr_cnt, 0);
    chk("R10 burst addr", addr_bad, 0);
    chk("R10 burst done", pd_first, 5);

    summary();
    $finish;
  end

endmodule